// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt output to a processor. Software writes a short run of setup words through an 8-bit port with one address bit. That run places the block in a cascade, sets the vector base, and selects 8086 vector mode. After setup, the same port loads the line mask, issues end-of-interrupt commands and chooses which internal register an even-address read returns. When the processor acknowledges, the block returns a vector made of the base's upper five bits followed by the winning line number.

Two copies can be chained. The slave's interrupt output drives one request line of the master. The master flags its acknowledge as a cascade cycle and names the line, so that only the matching slave supplies the vector. Priority is fixed, with line 0 highest. A special mask mode lets masked in-service levels stop blocking lower-priority lines. Request lines are edge sensitive.

Top module: `pic8_cascade`

## Requirements
- R1: After reset the mask reads 0xFF at the odd address, the request and in-service registers are zero, and int_out and vec_oe are low.
- R2: An even-address write with bit 4 set (for example 0x11) starts setup. It clears the mask, request register, in-service register, special mask mode and read select. The next odd write sets the vector base, of which bits 7:3 are used. int_out stays low until the setup run is complete.
- R3: In a cascaded setup (bit 1 of the first word clear), the third word is a line bitmap of attached slaves on a master, or the 3-bit identity of the master line on a slave. A fourth word is consumed, not loaded as a mask, when bit 0 of the first word is set.
- R4: After setup, odd-address writes load the mask register, where a set bit blocks that line. Odd-address reads return the mask.
- R5: int_out is high only when setup is complete and an unmasked pending line exists whose index is lower than every in-service level that still blocks.
- R6: On ack_in while int_out is high, the lowest-index unmasked pending line wins. Its request bit clears and its in-service bit sets. One cycle later vec_out = {base[7:3], line} with vec_oe high.
- R7: Even write 0x68 (bits 6 and 5 set, bit 3 set) enters special mask mode and 0x48 leaves it. In the mode, in-service bits whose mask bit is set do not block.
- R8: Even write 0x0A makes even reads return the request register, and 0x0B makes them return the in-service register.
- R9: Even write 0x60|L clears in-service bit L only. Even write 0x20 clears the highest-priority set in-service bit.
- R10: On a master, an acknowledged line whose bit is set in the slave bitmap raises casc_en_out with casc_id_out = line in the ack cycle, and the master keeps vec_oe low. A slave acts on ack_in only when casc_en_in is high and casc_id_in equals its identity.
- R11: A master line serving a slave stays in service until an EOI for that line is sent to the master. Until then, further slave requests do not raise the master's int_out.
- R12: A request bit latches on a 0-to-1 transition of its input. A line held high after service is not latched again.
- R13: When an EOI and an acknowledge fall in one cycle, the EOI clear applies first and the acknowledge's set second. When a new edge and the acknowledge clear hit the same line, the request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_a0 | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: mask at odd address, request or in-service register at even address |
| req_in | input | 8 | Interrupt request lines, line 0 highest |
| is_master | input | 1 | High for the master role, low for a slave |
| casc_en_in | input | 1 | Cascade acknowledge flag from the master (used by a slave) |
| casc_id_in | input | 3 | Line named by the master for the cascade acknowledge |
| casc_en_out | output | 1 | Master: the current acknowledge belongs to a slave |
| casc_id_out | output | 3 | Master: winning line number during the acknowledge |
| int_out | output | 1 | Interrupt to the processor or to the master |
| ack_in | input | 1 | Interrupt acknowledge, one cycle |
| vec_out | output | 8 | Returned vector |
| vec_oe | output | 1 | vec_out is valid this cycle |

## Verification
Two collisions are provoked on purpose. The first is an acknowledge that lands in the same cycle as a specific EOI naming the very level being acknowledged. The second is an acknowledge that lands in the same cycle as a fresh rising edge on the winning line. Both are driven as directed cases, and the random phase also mixes acknowledges with EOI and mask writes in single cycles. Each outcome is judged by reading back the in-service and request registers and comparing them, along with int_out and the vector, against a bench model that applies the clear-then-set order.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int HI_W  = 8 - IDX_W;

    typedef logic [LINES-1:0] lines_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {SEQ_READY, SEQ_BASE, SEQ_CASC, SEQ_MODE} seq_e;

    typedef struct packed {
        logic [HI_W-1:0] vec_hi;
        lines_t          casc_map;
        idx_t            own_id;
        logic            smm;
        logic            rd_isr;
        logic            want_mode;
        logic            solo;
    } cfg_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } pick_t;

    localparam logic [2:0] OP_EOI_SPEC = 3'b011;
    localparam logic [2:0] OP_EOI_ANY  = 3'b001;

    function automatic pick_t first_set(lines_t v);
        pick_t p;
        p = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic lines_t onehot(idx_t i);
        return lines_t'(1) << i;
    endfunction
endpackage

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       a0,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       is_master,
    output cfg_t       cfg,
    output lines_t     imr,
    output logic       ready,
    output logic       init_clr,
    output logic       eoi_spec,
    output logic       eoi_any,
    output idx_t       eoi_lvl
);
    seq_e st;
    logic cmd_ok;

    assign ready    = (st == SEQ_READY);
    assign init_clr = wr & ~a0 & wdata[4];
    assign cmd_ok   = wr & ~a0 & ~wdata[4] & ready;
    assign eoi_spec = cmd_ok & ~wdata[3] & (wdata[7:5] == OP_EOI_SPEC);
    assign eoi_any  = cmd_ok & ~wdata[3] & (wdata[7:5] == OP_EOI_ANY);
    assign eoi_lvl  = wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_READY;
            imr <= '1;
            cfg <= '0;
        end else if (init_clr) begin
            st            <= SEQ_BASE;
            imr           <= '0;
            cfg.smm       <= 1'b0;
            cfg.rd_isr    <= 1'b0;
            cfg.want_mode <= wdata[0];
            cfg.solo      <= wdata[1];
        end else if (wr && a0) begin
            case (st)
                SEQ_BASE: begin
                    cfg.vec_hi <= wdata[7:IDX_W];
                    if (!cfg.solo)         st <= SEQ_CASC;
                    else if (cfg.want_mode) st <= SEQ_MODE;
                    else                   st <= SEQ_READY;
                end
                SEQ_CASC: begin
                    if (is_master) cfg.casc_map <= wdata;
                    else           cfg.own_id   <= wdata[IDX_W-1:0];
                    st <= cfg.want_mode ? SEQ_MODE : SEQ_READY;
                end
                SEQ_MODE: st  <= SEQ_READY;
                default:  imr <= wdata;
            endcase
        end else if (cmd_ok && wdata[3]) begin
            if (wdata[6]) cfg.smm    <= wdata[5];
            if (wdata[1]) cfg.rd_isr <= wdata[0];
        end
    end

    AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        init_clr |=> (imr == '0 && !ready)); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && a0 && ready) |=> (imr == $past(wdata))); // R4
endmodule

// File: rtl/pic_req_edge.sv
module pic_req_edge
    import pic_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t req,
    input  lines_t take_clr,
    input  logic   flush,
    output lines_t irr
);
    lines_t prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= req;
            if (flush) irr <= '0;
            else       irr <= (irr & ~take_clr) | (req & ~prev);
        end
    end

    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~$past(irr)) & ~$past(req)) == '0); // R12
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  lines_t irr,
    input  lines_t isr,
    input  lines_t imr,
    input  logic   smm,
    input  logic   ready,
    output logic   int_req,
    output idx_t   win
);
    lines_t pend;
    lines_t blk;
    pick_t  p_pend;
    pick_t  p_blk;

    always_comb begin
        pend    = irr & ~imr;
        blk     = smm ? (isr & ~imr) : isr;
        p_pend  = first_set(pend);
        p_blk   = first_set(blk);
        win     = p_pend.idx;
        int_req = ready & p_pend.hit & (!p_blk.hit || (p_pend.idx < p_blk.idx));
    end
endmodule

// File: rtl/pic8_cascade.sv
module pic8_cascade
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_a0,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] req_in,
    input  logic       is_master,
    input  logic       casc_en_in,
    input  logic [2:0] casc_id_in,
    output logic       casc_en_out,
    output logic [2:0] casc_id_out,
    output logic       int_out,
    input  logic       ack_in,
    output logic [7:0] vec_out,
    output logic       vec_oe
);
    cfg_t   cfg;
    lines_t imr, irr, isr, eoi_clr, set_v;
    logic   ready, init_clr, eoi_spec, eoi_any;
    idx_t   eoi_lvl, win;
    logic   int_req, ack_eff, take;
    pick_t  top_isr;

    pic_cfg_seq u_cfg (
        .clk(clk), .rst(rst), .a0(bus_a0), .wr(bus_wr), .wdata(bus_wdata),
        .is_master(is_master), .cfg(cfg), .imr(imr), .ready(ready),
        .init_clr(init_clr), .eoi_spec(eoi_spec), .eoi_any(eoi_any),
        .eoi_lvl(eoi_lvl)
    );

    pic_req_edge u_req (
        .clk(clk), .rst(rst), .req(req_in), .take_clr(set_v),
        .flush(init_clr), .irr(irr)
    );

    pic_resolver u_res (
        .irr(irr), .isr(isr), .imr(imr), .smm(cfg.smm), .ready(ready),
        .int_req(int_req), .win(win)
    );

    assign ack_eff = is_master ? ack_in
                               : (ack_in & casc_en_in & (casc_id_in == cfg.own_id));
    assign take    = ack_eff & int_req;
    assign set_v   = take ? onehot(win) : '0;

    always_comb begin
        top_isr = first_set(isr);
        if (eoi_spec)                  eoi_clr = onehot(eoi_lvl);
        else if (eoi_any && top_isr.hit) eoi_clr = onehot(top_isr.idx);
        else                           eoi_clr = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || init_clr) isr <= '0;
        else                 isr <= (isr & ~eoi_clr) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out <= '0;
            vec_oe  <= 1'b0;
        end else begin
            vec_oe <= take & ~(is_master & cfg.casc_map[win]);
            if (take) vec_out <= {cfg.vec_hi, win};
        end
    end

    assign int_out     = int_req;
    assign casc_en_out = is_master & take & cfg.casc_map[win];
    assign casc_id_out = win;
    assign bus_rdata   = bus_a0 ? imr : (cfg.rd_isr ? isr : irr);

    AST_INT_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr) != '0)); // R5
    AST_TAKE_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
        (take && !init_clr) |=> ((isr & onehot($past(win))) != '0)); // R6
    AST_ONE_NEW_ISR: assert property (@(posedge clk) disable iff (rst)
        $countones(isr & ~$past(isr)) <= 1); // R6
    AST_SPEC_EOI: assert property (@(posedge clk) disable iff (rst)
        (eoi_spec && !(take && win == eoi_lvl)) |=> ((isr & onehot($past(eoi_lvl))) == '0)); // R9
    AST_CASC_QUIET: assert property (@(posedge clk) disable iff (rst)
        casc_en_out |=> !vec_oe); // R10
    AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> (vec_out[7:IDX_W] == cfg.vec_hi)); // R2
endmodule

// File: tb/sim_pic8_cascade.sv
module sim_pic8_cascade;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       m_a0 = 0, m_wr = 0, s_a0 = 0, s_wr = 0, ack = 0;
    logic [7:0] m_wd = 0, s_wd = 0, m_req = 0, s_req = 0;
    logic [7:0] m_rd, s_rd, m_vec, s_vec;
    logic       m_int, s_int, m_oe, s_oe, m_cen, s_cen;
    logic [2:0] m_cid, s_cid;
    logic [7:0] m_lines;
    assign m_lines = {m_req[7:3], s_int, m_req[1:0]};

    pic8_cascade u0 (
        .clk(clk), .rst(rst), .bus_a0(m_a0), .bus_wr(m_wr), .bus_wdata(m_wd),
        .bus_rdata(m_rd), .req_in(m_lines), .is_master(1'b1), .casc_en_in(1'b0),
        .casc_id_in(3'd0), .casc_en_out(m_cen), .casc_id_out(m_cid),
        .int_out(m_int), .ack_in(ack), .vec_out(m_vec), .vec_oe(m_oe)
    );
    pic8_cascade u1 (
        .clk(clk), .rst(rst), .bus_a0(s_a0), .bus_wr(s_wr), .bus_wdata(s_wd),
        .bus_rdata(s_rd), .req_in(s_req), .is_master(1'b0), .casc_en_in(m_cen),
        .casc_id_in(m_cid), .casc_en_out(s_cen), .casc_id_out(s_cid),
        .int_out(s_int), .ack_in(ack), .vec_out(s_vec), .vec_oe(s_oe)
    );

    int  nchk = 0, nbad = 0;
    bit  done = 0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask
    task automatic mwr(logic a, logic [7:0] d);
        m_a0 = a; m_wr = 1; m_wd = d; @(negedge clk); m_wr = 0; m_a0 = 0;
    endtask
    task automatic swr(logic a, logic [7:0] d);
        s_a0 = a; s_wr = 1; s_wd = d; @(negedge clk); s_wr = 0; s_a0 = 0;
    endtask
    task automatic mrd(logic a, output logic [7:0] v); m_a0 = a; #1 v = m_rd; m_a0 = 0; endtask
    task automatic srd(logic a, output logic [7:0] v); s_a0 = a; #1 v = s_rd; s_a0 = 0; endtask
    task automatic do_ack(); ack = 1; @(negedge clk); ack = 0; endtask

    function automatic logic [3:0] first(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return {1'b1, 3'(i)};
        return 4'b0;
    endfunction
    function automatic logic mdl_int(logic [7:0] irr, isr, imr, logic smm);
        logic [3:0] p, b;
        p = first(irr & ~imr);
        b = first(smm ? (isr & ~imr) : isr);
        return p[3] && (!b[3] || p[2:0] < b[2:0]);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] mirr, misr, mimr, mprev, reqv, clr, exp_vec;
        logic       msmm, exp_v, take;
        logic [3:0] w, t;
        int         r;
        void'($urandom(32'd4711));
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 int", {7'b0, m_int}, 8'h0);
        mrd(1, v); chk("R1 mask", v, 8'hFF);
        mrd(0, v); chk("R1 irr", v, 8'h00);
        chk("R1 vec_oe", {7'b0, m_oe}, 8'h0);
        // setup both
        mwr(0, 8'h11); mrd(1, v); chk("R2 mask cleared", v, 8'h00);
        mwr(1, 8'h00); mwr(1, 8'h04); mwr(1, 8'h01);
        mwr(1, 8'hFF); mwr(0, 8'h68); mwr(0, 8'h0A);
        mrd(1, v); chk("R3 fourth word consumed, R4 mask", v, 8'hFF);
        swr(0, 8'h11); swr(1, 8'h08); swr(1, 8'h02); swr(1, 8'h01);
        swr(1, 8'hFF); swr(0, 8'h68); swr(0, 8'h0A);
        mwr(1, 8'h00); swr(1, 8'h00);
        // basic acknowledge
        m_req[5] = 1; cyc();
        chk("R5 int", {7'b0, m_int}, 8'h1);
        mrd(0, v); chk("R12 irr latched", v, 8'h20);
        do_ack();
        chk("R6 vec", m_vec, 8'h05); chk("R6 oe", {7'b0, m_oe}, 8'h1);
        mrd(0, v); chk("R6 irr cleared", v, 8'h00);
        mwr(0, 8'h0B); mrd(0, v); chk("R8 isr read", v, 8'h20);
        cyc(); cyc();
        mwr(0, 8'h0A); mrd(0, v); chk("R12 held high", v, 8'h00);
        mwr(0, 8'h0B);
        // special mask mode
        m_req[6] = 1; cyc();
        chk("R5 blocked by isr", {7'b0, m_int}, 8'h0);
        mwr(1, 8'h20); chk("R7 smm unblocks", {7'b0, m_int}, 8'h1);
        mwr(0, 8'h48); chk("R7 smm off", {7'b0, m_int}, 8'h0);
        mwr(0, 8'h68); chk("R7 smm on", {7'b0, m_int}, 8'h1);
        mwr(1, 8'h00); chk("R7 unmasked isr blocks", {7'b0, m_int}, 8'h0);
        // EOI forms
        mwr(0, 8'h65); mrd(0, v); chk("R9 spec eoi", v, 8'h00);
        do_ack(); chk("R6 vec6", m_vec, 8'h06);
        m_req[1] = 1; cyc(); chk("R5 nesting", {7'b0, m_int}, 8'h1);
        do_ack(); chk("R6 vec1", m_vec, 8'h01);
        mrd(0, v); chk("R6 isr", v, 8'h42);
        mwr(0, 8'h20); mrd(0, v); chk("R9 nonspec eoi", v, 8'h40);
        mwr(0, 8'h66); m_req = 0; cyc();
        // fixed priority
        m_req[7] = 1; m_req[3] = 1; cyc();
        do_ack(); chk("R6 priority", m_vec, 8'h03);
        chk("R5 lower blocked", {7'b0, m_int}, 8'h0);
        mwr(0, 8'h63); do_ack(); chk("R6 vec7", m_vec, 8'h07);
        mwr(0, 8'h67); m_req = 0; cyc();
        // same-cycle ack and EOI
        m_req[4] = 1; cyc(); do_ack(); chk("R6 vec4", m_vec, 8'h04);
        m_req[3] = 1; cyc();
        m_a0 = 0; m_wr = 1; m_wd = 8'h63; ack = 1; @(negedge clk); m_wr = 0; ack = 0;
        chk("R13 vec", m_vec, 8'h03);
        mrd(0, v); chk("R13 isr set after clear", v, 8'h18);
        mwr(0, 8'h63); mwr(0, 8'h64); m_req = 0; cyc();
        // same-cycle ack and new edge
        m_req[6] = 1; cyc(); m_req[6] = 0; cyc();
        m_req[6] = 1; ack = 1; @(negedge clk); ack = 0;
        chk("R13 vec6", m_vec, 8'h06);
        mwr(0, 8'h0A); mrd(0, v); chk("R13 irr kept", v, 8'h40);
        mwr(0, 8'h0B); mwr(0, 8'h66);
        do_ack(); chk("R13 relatched vec", m_vec, 8'h06);
        mwr(0, 8'h66); m_req = 0; cyc();
        // cascade
        s_req[3] = 1; cyc(); cyc();
        chk("R10 master int", {7'b0, m_int}, 8'h1);
        ack = 1; #1;
        chk("R10 casc_en", {7'b0, m_cen}, 8'h1);
        chk("R10 casc_id", {5'b0, m_cid}, 8'h02);
        @(negedge clk); ack = 0;
        chk("R3 slave vector", s_vec, 8'h0B);
        chk("R10 slave oe", {7'b0, s_oe}, 8'h1);
        chk("R10 master quiet", {7'b0, m_oe}, 8'h0);
        mrd(0, v); chk("R11 master isr", v, 8'h04);
        s_req[1] = 1; cyc(); cyc();
        chk("R11 slave int", {7'b0, s_int}, 8'h1);
        chk("R11 master held", {7'b0, m_int}, 8'h0);
        mwr(0, 8'h62); chk("R11 released", {7'b0, m_int}, 8'h1);
        do_ack(); chk("R11 slave vec", s_vec, 8'h09);
        swr(0, 8'h61); swr(0, 8'h63); mwr(0, 8'h62);
        s_req[5] = 1; m_req[0] = 1; cyc(); cyc();
        do_ack();
        chk("R10 master vec0", m_vec, 8'h00);
        chk("R10 slave ignores", {7'b0, s_oe}, 8'h0);
        swr(0, 8'h0A); srd(0, v); chk("R10 slave irr kept", v, 8'h20);
        swr(1, 8'hFF); s_req = 0; m_req = 0; mwr(0, 8'h60); cyc();
        // re-setup of master
        mwr(0, 8'h11); m_req[0] = 1; cyc();
        chk("R2 int low in setup", {7'b0, m_int}, 8'h0);
        mwr(1, 8'h00); mwr(1, 8'h04); mwr(1, 8'h01);
        chk("R2 int after setup", {7'b0, m_int}, 8'h1);
        do_ack(); chk("R6 vec0", m_vec, 8'h00);
        mwr(0, 8'h60); m_req[0] = 0; mwr(0, 8'h0B); cyc();
        // random phase
        mirr = 0; misr = 0; mimr = 0; msmm = 0; mprev = 0; exp_v = 0; exp_vec = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            m_wr = 0; m_a0 = 0; ack = 0; #1;
            chk("R5 rand int", {7'b0, m_int}, {7'b0, mdl_int(mirr, misr, mimr, msmm)});
            chk("R9 rand isr", m_rd, misr);
            if (exp_v) begin
                chk("R6 rand vec", m_vec, exp_vec);
                chk("R6 rand oe", {7'b0, m_oe}, 8'h1);
            end
            m_req = m_req ^ (8'($urandom) & 8'($urandom) & 8'($urandom) & 8'hFB);
            r = int'($urandom % 100);
            clr = 0;
            if (r < 15 || (r >= 40 && r < 50)) ack = 1;
            if ((r >= 15 && r < 25) || (r >= 40 && r < 50)) begin
                m_wd = 8'h60 | 8'($urandom % 8); m_wr = 1;
                clr = 8'h1 << m_wd[2:0];
            end else if (r >= 25 && r < 30) begin
                m_wd = 8'h20; m_wr = 1;
                t = first(misr);
                if (t[3]) clr = 8'h1 << t[2:0];
            end else if (r >= 30 && r < 35) begin
                m_wd = 8'($urandom); m_wr = 1; m_a0 = 1;
            end else if (r >= 35 && r < 40) begin
                m_wd = ($urandom % 2 == 0) ? 8'h68 : 8'h48; m_wr = 1;
            end
            reqv = {m_req[7:3], 1'b0, m_req[1:0]};
            w = first(mirr & ~mimr);
            take = ack && mdl_int(mirr, misr, mimr, msmm);
            misr = (misr & ~clr) | (take ? (8'h1 << w[2:0]) : 8'h0);
            mirr = (mirr & ~(take ? (8'h1 << w[2:0]) : 8'h0)) | (reqv & ~mprev);
            mprev = reqv;
            if (m_wr && m_a0) mimr = m_wd;
            if (m_wr && !m_a0 && (m_wd == 8'h68 || m_wd == 8'h48)) msmm = m_wd[5];
            exp_v = take;
            exp_vec = {5'b0, w[2:0]};
        end
        @(negedge clk); m_wr = 0; ack = 0;
        finish_run();
    end
endmodule